// File: doc/BRIEF.md
# Time-Shared Carry Select Adder

This block adds two unsigned operands and reports a registered sum and carry-out. Like any carry select adder, it splits the word into a plain ripple section for the lowest bits and a series of upper groups. Each upper group normally needs two precomputed results, one for an incoming carry of one and one for zero. Here each group has only a single ripple adder, which is used twice. Its carry-in follows a phase input. In a high phase the group computes with carry-in one and keeps that result in a small per-group register bank. In the following low phase the same adder computes with carry-in zero. A 2:1 selector in each group then picks the kept result or the live one, steered by the true carry coming up from the group below.

The surrounding logic runs one addition as a high-phase cycle followed by a low-phase cycle, with the operands held steady across both. At the end of that low cycle, the selected sum and carry-out are registered and a one-cycle completion pulse is raised. The ripple-section width and the group width are parameters. With the defaults (16 bits, 2-bit ripple section, 4-bit groups), the upper 14 bits form groups of 4, 4, 4 and 2 bits.

Top module: `tsca_adder`

## Requirements
- R1: When a completion pulse is raised, {cout, sum} equals the unsigned sum of the operands that were present during the low-phase cycle, taken modulo 2^(WIDTH+1). The operands are held from the preceding high-phase cycle.
- R2: The completion output `vld` is high for exactly one cycle. It rises only at the clock edge that ends a low-phase cycle (`ph_en`=0) which directly follows a high-phase cycle (`ph_en`=1).
- R3: A low-phase cycle that does not directly follow a high-phase cycle raises no completion pulse and leaves `sum` and `cout` unchanged, whatever the operands.
- R4: A high-phase cycle never raises the completion pulse and leaves `sum` and `cout` unchanged, whatever the operands.
- R5: An active-low reset clears `sum`, `cout`, `vld`, the kept carry-in-one results and the pending high-phase state. A low-phase cycle right after reset release therefore completes nothing, even if a high phase came just before the reset.
- R6: The carry from the ripple section and from every group crosses into the next group. For example, an operand with ones in all bits below a boundary, plus one, yields a single set bit at that boundary. With the defaults, the boundaries are at bits 2, 6, 10 and 14.
- R7: When several high-phase cycles come in a row, the result kept for the low phase is the one from the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_en | input | 1 | Phase select: 1 = carry-in-one phase, 0 = carry-in-zero phase |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| sum | output | WIDTH | Registered sum of the last completed addition |
| cout | output | 1 | Registered carry-out of the last completed addition |
| vld | output | 1 | One-cycle pulse marking a completed addition |

## Verification
The sum check compares against the operands sampled during the low cycle. It therefore takes for granted that the operands did not change between the high and the low cycle of one addition. The exception is a run of several high cycles, where only the last of them counts. The bench drives each addition as a high cycle and a low cycle with one operand pair applied at the start of the high cycle. It changes operands only on cycles that complete nothing: repeated high phases, lone low phases and reset. All inputs change at the falling clock edge.

// File: rtl/tsca_pkg.sv
package tsca_pkg;

    // Number of upper select groups covering the bits above the ripple section.
    function automatic int grp_count(int width, int low_w, int gw);
        return (width - low_w + gw - 1) / gw;
    endfunction

    // Lowest bit index of upper group g.
    function automatic int grp_base(int low_w, int gw, int g);
        return low_w + g * gw;
    endfunction

    // Width of upper group g; the topmost group takes the remainder.
    function automatic int grp_size(int width, int low_w, int gw, int g);
        int rest;
        rest = width - low_w - g * gw;
        return (rest < gw) ? rest : gw;
    endfunction

endpackage

// File: rtl/tsca_ripple.sv
module tsca_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign co = c[W];
endmodule

// File: rtl/tsca_grp.sv
module tsca_grp #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ph_en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_c,
    output logic [W-1:0] s,
    output logic         co
);
    typedef struct packed {
        logic [W-1:0] s;
        logic         c;
    } res_t;

    res_t live;
    res_t keep_d;
    res_t keep_q;

    // Single adder: carry-in follows the phase.
    tsca_ripple #(.W(W)) u_rca (
        .a   (a),
        .b   (b),
        .cin (ph_en),
        .s   (live.s),
        .co  (live.c)
    );

    always_comb begin
        keep_d = keep_q;
        if (ph_en) begin
            keep_d = live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else begin
            keep_q <= keep_d;
        end
    end

    // True carry from below picks the kept carry-in-one result or the live one.
    assign s  = sel_c ? keep_q.s : live.s;
    assign co = sel_c ? keep_q.c : live.c;
endmodule

// File: rtl/tsca_adder.sv
module tsca_adder #(
    parameter int WIDTH = 16,
    parameter int LOW_W = 2,
    parameter int GRP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ph_en,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             vld
);
    localparam int NGRP = tsca_pkg::grp_count(WIDTH, LOW_W, GRP_W);

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
        logic             vld;
        logic             armed;
    } st_t;

    st_t              st_d;
    st_t              st_q;
    logic [WIDTH-1:0] comb_sum;
    logic [NGRP:0]    carry;

    // Plain ripple section for the lowest bits.
    tsca_ripple #(.W(LOW_W)) u_low (
        .a   (a[LOW_W-1:0]),
        .b   (b[LOW_W-1:0]),
        .cin (1'b0),
        .s   (comb_sum[LOW_W-1:0]),
        .co  (carry[0])
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = tsca_pkg::grp_base(LOW_W, GRP_W, g);
        localparam int GW = tsca_pkg::grp_size(WIDTH, LOW_W, GRP_W, g);

        tsca_grp #(.W(GW)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .ph_en (ph_en),
            .a     (a[LO +: GW]),
            .b     (b[LO +: GW]),
            .sel_c (carry[g]),
            .s     (comb_sum[LO +: GW]),
            .co    (carry[g+1])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (ph_en) begin
            st_d.armed = 1'b1;
        end else begin
            if (st_q.armed) begin
                st_d.sum  = comb_sum;
                st_d.cout = carry[NGRP];
                st_d.vld  = 1'b1;
            end
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum  = st_q.sum;
    assign cout = st_q.cout;
    assign vld  = st_q.vld;
endmodule

// File: rtl/tsca_adder_chk.sv
module tsca_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ph_en,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             vld
);
    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)})));

    assert_after_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (!$past(ph_en) && $past(ph_en, 2)));

    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vld |=> !vld);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> ($stable(sum) && $stable(cout)));

    assert_high_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ph_en |=> !vld);
endmodule

bind tsca_adder tsca_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ph_en (ph_en),
    .a     (a),
    .b     (b),
    .sum   (sum),
    .cout  (cout),
    .vld   (vld)
);

// File: tb/tsca_adder_tb.sv
`timescale 1ns/1ps
module tsca_adder_tb_top;
    localparam int W  = 16;
    localparam int NV = 12;

    localparam logic [W-1:0] VA [NV] = '{
        16'h0000, 16'hFFFF, 16'hFFFF, 16'h0003, 16'h003F, 16'h03FF,
        16'h3FFF, 16'h8000, 16'h1234, 16'hA5A5, 16'hFFFF, 16'h7FFF};
    localparam logic [W-1:0] VB [NV] = '{
        16'h0000, 16'h0001, 16'hFFFF, 16'h0001, 16'h0001, 16'h0001,
        16'h0001, 16'h8000, 16'h4321, 16'h5A5A, 16'h0000, 16'h0001};
    localparam logic [W:0] VE [NV] = '{
        17'h00000, 17'h10000, 17'h1FFFE, 17'h00004, 17'h00040, 17'h00400,
        17'h04000, 17'h10000, 17'h05555, 17'h0FFFF, 17'h0FFFF, 17'h08000};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ph_en = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] sum;
    logic         cout;
    logic         vld;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    tsca_adder #(.WIDTH(W), .LOW_W(2), .GRP_W(4)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_en (ph_en),
        .a     (a),
        .b     (b),
        .sum   (sum),
        .cout  (cout),
        .vld   (vld)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // High cycle then low cycle; called and returns at a falling edge.
    task automatic add_pair(input logic [W-1:0] x, input logic [W-1:0] y,
                            input logic [W:0] exp, input string req);
        a = x; b = y; ph_en = 1'b1;
        @(negedge clk);
        chk({req, " no pulse in high phase"}, {31'd0, vld}, 32'd0);
        ph_en = 1'b0;
        @(negedge clk);
        chk({req, " pulse"}, {31'd0, vld}, 32'd1);
        chk({req, " result"}, {15'd0, cout, sum}, {15'd0, exp});
    endtask

    initial begin
        logic [W:0] held;
        repeat (2) @(negedge clk);
        chk("R5 reset state", {15'd0, cout, sum, vld}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R6: vector table, includes carries across bits 2, 6, 10, 14
        for (int i = 0; i < NV; i++) begin
            add_pair(VA[i], VB[i], VE[i], "R1 R6 vector");
        end

        // R1: random operands
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            x = W'($urandom);
            y = W'($urandom);
            add_pair(x, y, {1'b0, x} + {1'b0, y}, "R1 random");
        end

        // R2: pulse lasts one cycle
        add_pair(16'h00FF, 16'h0F01, 17'h01000, "R2");
        @(negedge clk);
        chk("R2 pulse ends", {31'd0, vld}, 32'd0);
        held = {cout, sum};

        // R3: lone low phases with new operands change nothing
        for (int i = 0; i < 3; i++) begin
            a = 16'hFFFF; b = 16'h1111;
            @(negedge clk);
            chk("R3 no pulse", {31'd0, vld}, 32'd0);
            chk("R3 hold", {15'd0, cout, sum}, {15'd0, held});
        end

        // R4 R7: two high phases with different operands, last one counts
        a = 16'h1111; b = 16'h2222; ph_en = 1'b1;
        @(negedge clk);
        chk("R4 hold", {15'd0, cout, sum, vld}, {14'd0, held, 1'b0});
        a = 16'hF000; b = 16'h1001;
        @(negedge clk);
        chk("R4 hold second", {15'd0, cout, sum, vld}, {14'd0, held, 1'b0});
        ph_en = 1'b0;
        @(negedge clk);
        chk("R7 pulse", {31'd0, vld}, 32'd1);
        chk("R7 last high wins", {15'd0, cout, sum}, 32'h00010001);

        // R5: reset after a high phase drops the pending addition
        add_pair(16'h0101, 16'h0202, 17'h00303, "R5 pre");
        ph_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R5 cleared", {15'd0, cout, sum, vld}, 32'd0);
        rst_n = 1'b1;
        ph_en = 1'b0;
        @(negedge clk);
        chk("R5 no completion after reset", {15'd0, cout, sum, vld}, 32'd0);
        add_pair(16'hFFFF, 16'hFFFF, 17'h1FFFE, "R5 post");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule